// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits at the end of a channel-decoding pipeline. It takes decoded transport packets one byte at a time, together with a start-of-packet marker and a per-packet "could not be corrected" indication. It then presents every byte on two outputs at once. The first is an 8-bit parallel bus with its own byte clock and three qualifiers: byte valid, packet start and bad packet. The second is a bit-serial stream with a serial clock, a data line, a packet-start line and a bad-packet line. The serial stream also takes an enable input from the receiving side, and that input can pause it.

The serial signals share device pins with a test-access port. A strap input selects which use the pins have. While the strap is high, the serial port owns the pins through an output-enable. While it is low, the pins are released, the serial outputs stay quiet, and bytes are paced at the parallel rate only. Packet framing is regenerated internally. A byte counter restarts on every input start marker and, once locked, marks a new packet every `PKT_LEN` bytes even when the marker is missing. A one-entry holding buffer between the input and the output slot lets the serial receiver pause the stream without any byte being lost.

Top module: `ts_out_formatter`

## Requirements
- R1: While and after a synchronous reset, `par_valid`, `par_clk`, `par_data`, `par_sync`, `par_err`, `ser_clk`, `ser_data`, `ser_sync`, `ser_err` and `ser_oe` are all 0, and `in_ready` is 1.
- R2: Every byte accepted on `in_valid && in_ready` appears once on `par_data`, in order, none lost or repeated. `par_clk` rises exactly once per byte, in the middle of the byte slot.
- R3: When no byte occupies the output slot, `par_valid` is 0 and `par_clk`, `par_sync`, `par_err` and `ser_clk` are 0.
- R4: `par_sync` is 1 for the first byte of a packet. That is a byte accepted with `in_sop`=1, or, once locked, the byte that follows `PKT_LEN` bytes of one packet without a new marker.
- R5: `par_err` is 1 for every byte of a packet whose start byte was accepted with `in_err`=1. A packet opened by the counter alone carries `par_err`=0.
- R6: In a serial slot, the byte is sent most-significant bit first, one bit per `BIT_CYC` clock cycles. `ser_clk` is low in the first half of each bit period and high in the second half, and `ser_data` is stable across the rising edge.
- R7: `ser_sync` and `ser_err` carry the byte's packet-start and bad-packet flags for all 8 bit periods of that byte.
- R8: In serial mode the parallel bus presents the same byte during the same slot, and the slot lasts 8*`BIT_CYC` cycles. In parallel-only mode a slot lasts `PAR_CYC` cycles.
- R9: In a serial slot with `ser_en`=0, the slot timer halts: `ser_clk`, `par_clk` and `par_data` hold their values, `in_ready` falls once the holding buffer is full, and no byte is lost.
- R10: `ser_oe` equals `ser_strap` as sampled one clock earlier. The slot kind is taken from `ser_strap` when each byte is loaded. In a parallel slot `ser_en` has no effect and the serial outputs stay 0.
- R11: Before the first accepted byte with `in_sop`=1, no byte is flagged with `par_sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_err | input | 1 | Packet starting with this byte is uncorrectable (read with in_sop) |
| in_ready | output | 1 | Holding buffer can take a byte |
| par_clk | output | 1 | Parallel byte clock, rises mid-slot |
| par_data | output | 8 | Parallel byte |
| par_valid | output | 1 | Parallel bus holds a byte |
| par_sync | output | 1 | Parallel packet-start flag |
| par_err | output | 1 | Parallel bad-packet flag |
| ser_strap | input | 1 | 1: shared pins are the serial port, 0: released to test use |
| ser_en | input | 1 | Serial receiver enable, 0 pauses a serial slot |
| ser_clk | output | 1 | Serial bit clock |
| ser_data | output | 1 | Serial data, MSB first |
| ser_sync | output | 1 | Serial packet-start flag |
| ser_err | output | 1 | Serial bad-packet flag |
| ser_oe | output | 1 | Output enable of the shared pins |

## Verification
The bench builds the block with `PKT_LEN`=12, `BIT_CYC`=2 and `PAR_CYC`=4. The short packet length lets counter-only packet starts, and the clearing of the bad flag at such a start, occur dozens of times within a short run. The two-cycle bit period and four-cycle parallel slot keep serial bytes at 16 cycles. That leaves room for several serial pauses and for strap changes in the middle of a stream, alongside hundreds of random bytes with random packet markers.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

  // One byte travelling through the formatter with its packet flags.
  typedef struct packed {
    logic [7:0] data;
    logic       first;
    logic       bad;
  } ts_beat_t;

endpackage

// File: rtl/tsf_pkt_tag.sv
// Tags each accepted byte with packet-start and bad-packet flags.
module tsf_pkt_tag #(
  parameter int PKT_LEN = 188
) (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic sop,
  input  logic err_in,
  output logic tag_first,
  output logic tag_bad
);
  localparam int IW = $clog2(PKT_LEN);

  logic [IW-1:0] idx;
  logic          locked;
  logic          bad_q;
  logic          wrap_start;

  // A counter-opened packet only exists after the first real marker.
  assign wrap_start = locked && (idx == '0) && !sop;
  assign tag_first  = sop || wrap_start;
  assign tag_bad    = sop ? err_in : (wrap_start ? 1'b0 : bad_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      locked <= 1'b0;
      bad_q  <= 1'b0;
    end else if (acc) begin
      if (sop) begin
        idx    <= IW'(1);
        locked <= 1'b1;
        bad_q  <= err_in;
      end else begin
        if (wrap_start) bad_q <= 1'b0;
        if (idx == IW'(PKT_LEN - 1)) idx <= '0;
        else                         idx <= idx + IW'(1);
      end
    end
  end

endmodule

// File: rtl/tsf_hold1.sv
// Single-entry holding buffer between input and output slot.
module tsf_hold1
  import tsf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr,
  input  ts_beat_t wbeat,
  input  logic     rd,
  output ts_beat_t rbeat,
  output logic     full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      rbeat <= '0;
    end else begin
      if (wr) begin
        rbeat <= wbeat;
        full  <= 1'b1;
      end else if (rd) begin
        full  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tsf_slot_ctrl.sv
// Byte slot timer: loads bytes, picks slot length, halts on serial pause.
module tsf_slot_ctrl #(
  parameter int BIT_CYC = 2,
  parameter int PAR_CYC = 4,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          avail,
  input  logic          strap,
  input  logic          ser_en,
  output logic          take,
  output logic          busy,
  output logic          ser_slot,
  output logic [CW-1:0] cnt
);
  localparam int SER_LEN = 8 * BIT_CYC;

  logic [CW-1:0] last;
  logic          adv;
  logic          at_end;

  always_comb begin
    last   = ser_slot ? CW'(SER_LEN - 1) : CW'(PAR_CYC - 1);
    adv    = !(ser_slot && !ser_en);
    at_end = busy && (cnt == last) && adv;
    take   = avail && (!busy || at_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      ser_slot <= 1'b0;
      cnt      <= '0;
    end else if (take) begin
      busy     <= 1'b1;
      ser_slot <= strap;
      cnt      <= '0;
    end else if (busy && adv) begin
      if (cnt == last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt  <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/tsf_out_drv.sv
// Registered parallel and serial output drivers.
module tsf_out_drv
  import tsf_pkg::*;
#(
  parameter int BIT_CYC = 2,
  parameter int PAR_CYC = 4,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          ser_slot,
  input  logic [CW-1:0] cnt,
  input  ts_beat_t      cur,
  input  logic          strap,
  output logic          par_clk,
  output logic [7:0]    par_data,
  output logic          par_valid,
  output logic          par_sync,
  output logic          par_err,
  output logic          ser_clk,
  output logic          ser_data,
  output logic          ser_sync,
  output logic          ser_err,
  output logic          ser_oe
);
  localparam int SER_LEN = 8 * BIT_CYC;
  localparam int SER_HI  = SER_LEN / 2;
  localparam int PAR_HI  = PAR_CYC / 2;
  localparam int BIT_HI  = BIT_CYC / 2;

  int unsigned c;
  int unsigned ph;
  logic [2:0]  bsel;
  logic        pclk_n;
  logic        sclk_n;
  logic        sbit_n;

  always_comb begin
    c      = int'(cnt);
    bsel   = 3'(c / BIT_CYC);
    ph     = c % BIT_CYC;
    pclk_n = (c >= (ser_slot ? SER_HI : PAR_HI));
    sclk_n = (ph >= BIT_HI);
    sbit_n = cur.data[3'd7 - bsel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      par_clk   <= 1'b0;
      par_data  <= '0;
      par_valid <= 1'b0;
      par_sync  <= 1'b0;
      par_err   <= 1'b0;
      ser_clk   <= 1'b0;
      ser_data  <= 1'b0;
      ser_sync  <= 1'b0;
      ser_err   <= 1'b0;
      ser_oe    <= 1'b0;
    end else begin
      ser_oe    <= strap;
      par_valid <= busy;
      par_clk   <= busy && pclk_n;
      par_data  <= busy ? cur.data : 8'h00;
      par_sync  <= busy && cur.first;
      par_err   <= busy && cur.bad;
      if (busy && ser_slot) begin
        ser_clk  <= sclk_n;
        ser_data <= sbit_n;
        ser_sync <= cur.first;
        ser_err  <= cur.bad;
      end else begin
        ser_clk  <= 1'b0;
        ser_data <= 1'b0;
        ser_sync <= 1'b0;
        ser_err  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ts_out_formatter.sv
// Transport stream output formatter: parallel and serial outputs at once.
module ts_out_formatter
  import tsf_pkg::*;
#(
  parameter int PKT_LEN = 188,
  parameter int BIT_CYC = 2,
  parameter int PAR_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_err,
  output logic       in_ready,
  output logic       par_clk,
  output logic [7:0] par_data,
  output logic       par_valid,
  output logic       par_sync,
  output logic       par_err,
  input  logic       ser_strap,
  input  logic       ser_en,
  output logic       ser_clk,
  output logic       ser_data,
  output logic       ser_sync,
  output logic       ser_err,
  output logic       ser_oe
);
  localparam int SER_LEN = 8 * BIT_CYC;
  localparam int MAX_LEN = (SER_LEN > PAR_CYC) ? SER_LEN : PAR_CYC;
  localparam int CW      = $clog2(MAX_LEN);

  logic          acc;
  logic          tag_first;
  logic          tag_bad;
  logic          full;
  logic          take;
  logic          busy;
  logic          ser_slot;
  logic [CW-1:0] cnt;
  ts_beat_t      in_beat;
  ts_beat_t      held;
  ts_beat_t      cur;

  assign in_ready = !full;
  assign acc      = in_valid && !full;

  always_comb begin
    in_beat.data  = in_data;
    in_beat.first = tag_first;
    in_beat.bad   = tag_bad;
  end

  tsf_pkt_tag #(.PKT_LEN(PKT_LEN)) u_tag (
    .clk(clk), .rst(rst), .acc(acc), .sop(in_sop), .err_in(in_err),
    .tag_first(tag_first), .tag_bad(tag_bad)
  );

  tsf_hold1 u_hold (
    .clk(clk), .rst(rst), .wr(acc), .wbeat(in_beat),
    .rd(take), .rbeat(held), .full(full)
  );

  tsf_slot_ctrl #(.BIT_CYC(BIT_CYC), .PAR_CYC(PAR_CYC), .CW(CW)) u_slot (
    .clk(clk), .rst(rst), .avail(full), .strap(ser_strap), .ser_en(ser_en),
    .take(take), .busy(busy), .ser_slot(ser_slot), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)       cur <= '0;
    else if (take) cur <= held;
  end

  tsf_out_drv #(.BIT_CYC(BIT_CYC), .PAR_CYC(PAR_CYC), .CW(CW)) u_drv (
    .clk(clk), .rst(rst), .busy(busy), .ser_slot(ser_slot), .cnt(cnt),
    .cur(cur), .strap(ser_strap),
    .par_clk(par_clk), .par_data(par_data), .par_valid(par_valid),
    .par_sync(par_sync), .par_err(par_err),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_sync(ser_sync),
    .ser_err(ser_err), .ser_oe(ser_oe)
  );

endmodule

// File: rtl/tsf_chk.sv
// Property checker attached to the formatter.
module tsf_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       ser_slot,
  input logic       ser_en,
  input logic       ser_strap,
  input logic       ser_oe,
  input logic       par_valid,
  input logic       par_clk,
  input logic [7:0] par_data,
  input logic       par_sync,
  input logic       par_err,
  input logic       ser_clk
);

  AST_SYNC_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    par_sync |-> par_valid); // R4

  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    par_err |-> par_valid); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !par_valid |-> (!par_clk && !ser_clk)); // R3

  AST_SER_WITH_PAR: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> par_valid); // R8

  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (busy && ser_slot && !ser_en) |=> ##1
      ($stable(ser_clk) && $stable(par_clk) && $stable(par_data))); // R9

  AST_OE_FOLLOWS_STRAP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ser_oe == $past(ser_strap))); // R10

endmodule

bind ts_out_formatter tsf_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .ser_slot(ser_slot), .ser_en(ser_en),
  .ser_strap(ser_strap), .ser_oe(ser_oe), .par_valid(par_valid),
  .par_clk(par_clk), .par_data(par_data), .par_sync(par_sync),
  .par_err(par_err), .ser_clk(ser_clk)
);

// File: tb/ts_out_formatter_tb.sv
module ts_out_formatter_tb;
  localparam int PKT_LEN  = 12;
  localparam int BIT_CYC  = 2;
  localparam int PAR_CYC  = 4;
  localparam int SER_SLOT = 8 * BIT_CYC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sop = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready;
  logic par_clk, par_valid, par_sync, par_err;
  logic [7:0] par_data;
  logic ser_strap = 1'b0, ser_en = 1'b1;
  logic ser_clk, ser_data, ser_sync, ser_err, ser_oe;

  always #5 clk = ~clk;

  ts_out_formatter #(.PKT_LEN(PKT_LEN), .BIT_CYC(BIT_CYC), .PAR_CYC(PAR_CYC)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_err(in_err), .in_ready(in_ready),
    .par_clk(par_clk), .par_data(par_data), .par_valid(par_valid),
    .par_sync(par_sync), .par_err(par_err),
    .ser_strap(ser_strap), .ser_en(ser_en),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_sync(ser_sync),
    .ser_err(ser_err), .ser_oe(ser_oe)
  );

  int errors = 0, checks = 0;
  int n_push = 0, par_seen = 0, ser_bytes = 0, sync_seen = 0;
  logic [7:0] exp_d [0:2047];
  logic       exp_f [0:2047];
  logic       exp_b [0:2047];
  logic m_locked = 1'b0, m_bad = 1'b0;
  int   m_idx = 0;
  int   cyc = 0, last_rise = -1, min_gap = PAR_CYC;
  int   sb = 0, sidx = 0;
  logic [7:0] sacc = 8'h00;
  logic prev_pc = 1'b0, prev_sc = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Expected flags from the packet rules (R4, R5, R11).
  task automatic push_exp(input logic [7:0] d, input logic s, input logic e);
    logic f, b;
    if (s) begin
      f = 1'b1; b = e; m_bad = e; m_idx = 1; m_locked = 1'b1;
    end else begin
      if (m_locked && m_idx == 0) begin
        f = 1'b1; b = 1'b0; m_bad = 1'b0;
      end else begin
        f = 1'b0; b = m_bad;
      end
      m_idx = (m_idx == PKT_LEN - 1) ? 0 : m_idx + 1;
    end
    exp_d[n_push] = d; exp_f[n_push] = f; exp_b[n_push] = b;
    n_push++;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sop = s; in_err = e;
    #4;
    while (!in_ready) begin
      @(negedge clk);
      #4;
    end
    push_exp(d, s, e);
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_sop = 1'b0; in_err = 1'b0;
  endtask

  task automatic send_rand(input int n);
    for (int i = 0; i < n; i++) begin
      logic s;
      s = (($urandom % 20) == 0);
      send_byte(8'($urandom), s, 1'($urandom));
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (par_seen == n_push && !par_valid) break;
    end
  endtask

  // Output monitor, sampled on falling edges.
  always @(negedge clk) begin
    if (rst) begin
      prev_pc = 1'b0; prev_sc = 1'b0;
    end else begin
      if (par_clk && !prev_pc) begin
        if (par_seen >= n_push) chk(1'b0, "R2 extra byte", par_seen, n_push);
        else begin
          chk(par_data == exp_d[par_seen], "R2 par_data", par_data, exp_d[par_seen]);
          chk(par_sync == exp_f[par_seen], "R4 par_sync", par_sync, exp_f[par_seen]);
          chk(par_err == exp_b[par_seen], "R5 par_err", par_err, exp_b[par_seen]);
          chk(par_valid, "R3 par_valid at byte clock", par_valid, 1);
        end
        if (par_sync) sync_seen++;
        if (last_rise >= 0)
          chk((cyc - last_rise) >= min_gap, "R8 slot spacing", cyc - last_rise, min_gap);
        last_rise = cyc;
        par_seen++;
      end
      if (ser_clk && !prev_sc) begin
        if (sb == 0) sidx = par_seen;
        sacc = {sacc[6:0], ser_data};
        chk(ser_sync == exp_f[sidx], "R7 ser_sync", ser_sync, exp_f[sidx]);
        chk(ser_err == exp_b[sidx], "R7 ser_err", ser_err, exp_b[sidx]);
        if (sb == 7) begin
          chk(sacc == exp_d[sidx], "R6 serial byte MSB first", sacc, exp_d[sidx]);
          ser_bytes++;
          sb = 0;
        end else sb++;
      end
      prev_pc = par_clk;
      prev_sc = ser_clk;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!par_valid && !par_clk && par_data == 8'h00 && !par_sync && !par_err,
        "R1 parallel reset", {par_valid, par_clk, par_sync, par_err}, 0);
    chk(!ser_clk && !ser_data && !ser_sync && !ser_err && !ser_oe,
        "R1 serial reset", {ser_clk, ser_data, ser_sync, ser_err, ser_oe}, 0);
    chk(in_ready, "R1 ready after reset", in_ready, 1);

    // Parallel-only phase, serial enable held low (R10 ignored)
    ser_en = 1'b0;
    min_gap = PAR_CYC;
    for (int i = 0; i < 5; i++) send_byte(8'(8'hA0 + i), 1'b0, 1'b0);
    drain();
    chk(sync_seen == 0, "R11 no sync before first marker", sync_seen, 0);
    chk(par_seen == 5, "R10 bytes flow with ser_en low", par_seen, 5);
    send_byte(8'h47, 1'b1, 1'b0);
    for (int i = 1; i < 3 * PKT_LEN + 3; i++) send_byte(8'(i), 1'b0, 1'b1);
    send_byte(8'h47, 1'b1, 1'b1);
    for (int i = 1; i < PKT_LEN + 3; i++) send_byte(8'(8'h80 + i), 1'b0, 1'b0);
    // back-to-back burst with no gaps
    send_rand(200);
    drain();
    chk(par_seen == n_push, "R2 all parallel bytes seen", par_seen, n_push);
    chk(ser_bytes == 0, "R10 serial quiet in parallel mode", ser_bytes, 0);
    chk(!par_valid && !par_clk, "R3 idle outputs", {par_valid, par_clk}, 0);

    // Serial phase with pauses
    @(negedge clk);
    ser_strap = 1'b1; ser_en = 1'b1;
    @(negedge clk);
    chk(ser_oe == 1'b1, "R10 ser_oe follows strap", ser_oe, 1);
    min_gap = SER_SLOT;
    base = ser_bytes;
    fork
      send_rand(300);
      begin
        for (int k = 0; k < 4; k++) begin
          logic hsc, hpc;
          logic [7:0] hpd;
          int bad;
          repeat (40 + ($urandom % 60)) @(negedge clk);
          ser_en = 1'b0;
          @(negedge clk);
          @(negedge clk);
          hsc = ser_clk; hpc = par_clk; hpd = par_data; bad = 0;
          repeat (20) begin
            @(negedge clk);
            if (ser_clk !== hsc || par_clk !== hpc || par_data !== hpd) bad++;
          end
          chk(bad == 0, "R9 pause freezes outputs", bad, 0);
          chk(in_ready == 1'b0, "R9 backpressure during pause", in_ready, 0);
          ser_en = 1'b1;
        end
      end
    join
    drain();
    chk(par_seen == n_push, "R9 no byte lost across pauses", par_seen, n_push);
    chk(ser_bytes - base == 300, "R8 every byte also sent serially", ser_bytes - base, 300);

    // Mixed phase: strap toggles while streaming
    min_gap = PAR_CYC;
    fork
      send_rand(100);
      begin
        for (int k = 0; k < 8; k++) begin
          repeat (37) @(negedge clk);
          ser_strap = ~ser_strap;
          @(negedge clk);
          chk(ser_oe == ser_strap, "R10 ser_oe after strap change", ser_oe, ser_strap);
        end
      end
    join
    drain();
    chk(par_seen == n_push, "R2 final byte count", par_seen, n_push);
    chk(sb == 0, "R6 no partial serial byte", sb, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule